// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between eight external interrupt request pins plus one non-maskable interrupt pin and a parent interrupt controller. Every pin passes through a synchroniser. The block then checks each line for the condition that software picked: low level, falling edge, rising edge or either edge. When the condition is met, it latches a pending flag for that line. Each pending flag drives the request wire of its line toward the parent. Priority and masking are left to the parent.

Software reaches the block through a small 16-bit register port with three registers. The first controls the non-maskable line: it gives its edge choice, its pending flag and a live view of its pin. The second holds the 2-bit sense choice for each line. The third holds the eight pending flags. A flag is acknowledged by writing zero to it. Writing one to a flag leaves it unchanged, so one line can be cleared without disturbing the others.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: Each pin passes through two synchroniser flops, and edges are found between the last two synchronised samples. A pin change driven before a rising clock edge sets its flag at the third rising edge, not earlier.
- R2: The sense register is at byte offset 2 and reads back what was written. Line n is controlled by bits [2n+1:2n]. Code 0 selects low level: the flag is set on every cycle the synchronised pin is low, so a clear written while the pin is low has no effect.
- R3: Sense code 1 sets the flag only on a high-to-low change of the synchronised pin.
- R4: Sense code 2 sets the flag only on a low-to-high change of the synchronised pin.
- R5: Sense code 3 sets the flag on a change of the synchronised pin in either direction.
- R6: The pending register is at byte offset 4, with the flag of line n at bit n. Writing 0 to a bit that is 1 clears that flag. Writing 1 leaves it unchanged. Bits [15:8] read as 0.
- R7: If a detection event and a clear of the same flag occur in the same cycle, the flag stays set.
- R8: The non-maskable control register is at byte offset 0. Bit 15 reads the synchronised pin level and ignores writes. Bit 8 selects the edge (0 falling, 1 rising). Bit 1 is the pending flag and clears in the same way as in R6. All other bits read 0.
- R9: Each line's request output equals that line's pending flag, and the non-maskable request output equals its pending flag. A flag only becomes set following a detection event.
- R10: After reset, the sense register, the edge select and all flags are 0. The synchronisers idle high, so pins held high cause no event. Offset 6 reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 8 | External interrupt pins, asynchronous |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, asynchronous |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Byte offset of the register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the register at reg_addr_i (combinational) |
| irq_req_o | output | 8 | Request for each line toward the parent controller |
| nmi_req_o | output | 1 | Non-maskable request toward the parent controller |

## Verification
Every combination of line and sense code is swept. The line under test gets a falling pin step and then a rising pin step, while all other lines are set to either-edge mode with their pins held steady. This separates the four sense codes from each other and also shows that one line's event never reaches a neighbour's flag. Clears written while a low-level pin is still low tell level behaviour apart from edge behaviour. A clear timed into the same cycle as an edge shows that the event wins. Walking-zero clear masks over a full set of flags confirm that each clear reaches one bit only. The non-maskable line is run with both edge selections and both pin directions.

// File: rtl/eisc_pkg.sv
package eisc_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW_LEVEL = 2'd0,
    SENSE_FALL      = 2'd1,
    SENSE_RISE      = 2'd2,
    SENSE_ANY_EDGE  = 2'd3
  } sense_e;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_NMI_CTRL = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_SENSE    = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PEND     = 3'd4;

  localparam int unsigned NMI_LEVEL_POS = 15;
  localparam int unsigned NMI_EDGE_POS  = 8;
  localparam int unsigned NMI_PEND_POS  = 1;

  // Detection condition for one line from the current and previous sample.
  function automatic logic sense_match(input sense_e mode, input logic cur, input logic prev);
    logic hit;
    case (mode)
      SENSE_LOW_LEVEL: hit = ~cur;
      SENSE_FALL:      hit = prev & ~cur;
      SENSE_RISE:      hit = ~prev & cur;
      default:         hit = prev ^ cur;
    endcase
    return hit;
  endfunction

  // Edge condition for the non-maskable line: rise_sel=1 rising, 0 falling.
  function automatic logic nmi_match(input logic rise_sel, input logic cur, input logic prev);
    return rise_sel ? (~prev & cur) : (prev & ~cur);
  endfunction

  // Next pending state: a write of 0 clears, a new event always wins.
  function automatic logic pend_next(input logic pend, input logic wr, input logic keep,
                                     input logic evt);
    return (pend & (~wr | keep)) | evt;
  endfunction

endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
  parameter int unsigned     WIDTH  = 9,
  parameter int unsigned     STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q[0] <= IDLE;
    end else begin
      pipe_q[0] <= pin_i;
    end
  end

  // Remaining synchroniser stages plus the history stage used for edges.
  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q[s] <= IDLE;
      end else begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign cur_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/eisc_detect.sv
module eisc_detect
  import eisc_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned CFG_W  = 2 * N_LINES
) (
  input  logic [CFG_W-1:0]   sense_cfg_i,
  input  logic [N_LINES-1:0] cur_i,
  input  logic [N_LINES-1:0] prev_i,
  input  logic               nmi_rise_sel_i,
  input  logic               nmi_cur_i,
  input  logic               nmi_prev_i,
  output logic [N_LINES-1:0] evt_o,
  output logic               nmi_evt_o
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign evt_o[i] = sense_match(sense_e'(sense_cfg_i[2*i +: 2]), cur_i[i], prev_i[i]);
  end

  assign nmi_evt_o = nmi_match(nmi_rise_sel_i, nmi_cur_i, nmi_prev_i);

endmodule

// File: rtl/eisc_pend.sv
module eisc_pend
  import eisc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] keep_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] pend_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_o[b] <= 1'b0;
      end else begin
        pend_o[b] <= pend_next(pend_o[b], wr_i, keep_i[b], evt_i[b]);
      end
    end
  end

endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
  import eisc_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned CFG_W  = 2 * N_LINES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_i,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [N_LINES-1:0]    pend_i,
  input  logic                  nmi_pend_i,
  input  logic                  nmi_level_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [CFG_W-1:0]      sense_q_o,
  output logic                  nmi_rise_q_o,
  output logic                  wr_sense_stb_o,
  output logic                  wr_pend_stb_o,
  output logic                  wr_nmi_stb_o
);

  logic wr_any;

  assign wr_any         = sel_i & wr_i;
  assign wr_sense_stb_o = wr_any & (addr_i == ADDR_SENSE);
  assign wr_pend_stb_o  = wr_any & (addr_i == ADDR_PEND);
  assign wr_nmi_stb_o   = wr_any & (addr_i == ADDR_NMI_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q_o    <= '0;
      nmi_rise_q_o <= 1'b0;
    end else begin
      if (wr_sense_stb_o) begin
        sense_q_o <= wdata_i[CFG_W-1:0];
      end
      if (wr_nmi_stb_o) begin
        nmi_rise_q_o <= wdata_i[NMI_EDGE_POS];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_NMI_CTRL: begin
        rdata_o[NMI_LEVEL_POS] = nmi_level_i;
        rdata_o[NMI_EDGE_POS]  = nmi_rise_q_o;
        rdata_o[NMI_PEND_POS]  = nmi_pend_i;
      end
      ADDR_SENSE: rdata_o[CFG_W-1:0]   = sense_q_o;
      ADDR_PEND:  rdata_o[N_LINES-1:0] = pend_i;
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import eisc_pkg::*;
#(
  parameter int unsigned N_LINES     = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_LINES-1:0]    irq_pin_i,
  input  logic                  nmi_pin_i,
  input  logic                  reg_sel_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [N_LINES-1:0]    irq_req_o,
  output logic                  nmi_req_o
);

  localparam int unsigned SYNC_W = N_LINES + 1;
  localparam int unsigned CFG_W  = 2 * N_LINES;

  // Named internal events, also observed by the bound checker.
  logic [SYNC_W-1:0]  sync_cur;
  logic [SYNC_W-1:0]  sync_prev;
  logic [N_LINES-1:0] irq_evt;
  logic               nmi_evt;
  logic [CFG_W-1:0]   sense_q;
  logic               nmi_rise_q;
  logic               wr_sense_stb;
  logic               wr_pend_stb;
  logic               wr_nmi_stb;
  logic [N_LINES-1:0] irq_pend;
  logic [0:0]         nmi_pend;

  eisc_sync #(
    .WIDTH (SYNC_W),
    .STAGES(SYNC_STAGES),
    .IDLE  ({SYNC_W{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({nmi_pin_i, irq_pin_i}),
    .cur_o (sync_cur),
    .prev_o(sync_prev)
  );

  eisc_detect #(
    .N_LINES(N_LINES)
  ) u_detect (
    .sense_cfg_i   (sense_q),
    .cur_i         (sync_cur[N_LINES-1:0]),
    .prev_i        (sync_prev[N_LINES-1:0]),
    .nmi_rise_sel_i(nmi_rise_q),
    .nmi_cur_i     (sync_cur[N_LINES]),
    .nmi_prev_i    (sync_prev[N_LINES]),
    .evt_o         (irq_evt),
    .nmi_evt_o     (nmi_evt)
  );

  eisc_pend #(
    .W(N_LINES)
  ) u_pend_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wr_pend_stb),
    .keep_i(reg_wdata_i[N_LINES-1:0]),
    .evt_i (irq_evt),
    .pend_o(irq_pend)
  );

  eisc_pend #(
    .W(1)
  ) u_pend_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wr_nmi_stb),
    .keep_i(reg_wdata_i[NMI_PEND_POS]),
    .evt_i (nmi_evt),
    .pend_o(nmi_pend)
  );

  eisc_regs #(
    .N_LINES(N_LINES),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (reg_sel_i),
    .wr_i          (reg_wr_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .pend_i        (irq_pend),
    .nmi_pend_i    (nmi_pend[0]),
    .nmi_level_i   (sync_cur[N_LINES]),
    .rdata_o       (reg_rdata_o),
    .sense_q_o     (sense_q),
    .nmi_rise_q_o  (nmi_rise_q),
    .wr_sense_stb_o(wr_sense_stb),
    .wr_pend_stb_o (wr_pend_stb),
    .wr_nmi_stb_o  (wr_nmi_stb)
  );

  assign irq_req_o = irq_pend;
  assign nmi_req_o = nmi_pend[0];

endmodule

// File: rtl/eisc_checker.sv
module eisc_checker #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned DATA_W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_LINES-1:0]   irq_evt,
  input logic [N_LINES-1:0]   irq_req,
  input logic                 nmi_evt,
  input logic                 nmi_req,
  input logic                 wr_pend_stb,
  input logic                 wr_nmi_stb,
  input logic                 wr_sense_stb,
  input logic [DATA_W-1:0]    wdata,
  input logic [2*N_LINES-1:0] sense_q
);

  // R9: a request only rises after a detection event in the previous cycle.
  assert_flag_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~$past(irq_req) & ~$past(irq_evt)) == '0));

  // R7: every detection event leaves its flag set, even against a clear.
  assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt != '0) |=> ((irq_req & $past(irq_evt)) == $past(irq_evt)));

  // R6: a flag falls only when the pending register was written with 0 there.
  assert_clear_only_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_req) & ~irq_req &
      ~({N_LINES{$past(wr_pend_stb)}} & ~$past(wdata[N_LINES-1:0]))) == '0));

  // R8: the non-maskable flag falls only on a control write with bit 1 low.
  assert_nmi_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_req) |-> $past(wr_nmi_stb && !wdata[1]));

  // R8: a non-maskable edge event sets the request in the next cycle.
  assert_nmi_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> nmi_req);

  // R2: sense configuration changes only through a write to its register.
  assert_sense_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sense_stb |=> $stable(sense_q));

endmodule

bind ext_irq_sense_ctrl eisc_checker #(
  .N_LINES(N_LINES),
  .DATA_W (DATA_W)
) u_eisc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_evt     (irq_evt),
  .irq_req     (irq_req_o),
  .nmi_evt     (nmi_evt),
  .nmi_req     (nmi_req_o),
  .wr_pend_stb (wr_pend_stb),
  .wr_nmi_stb  (wr_nmi_stb),
  .wr_sense_stb(wr_sense_stb),
  .wdata       (reg_wdata_i),
  .sense_q     (sense_q)
);

// File: tb/tb_ext_irq_sense_ctrl.sv
module tb_ext_irq_sense_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [7:0]  irq_req;
  logic        nmi_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pin_i  (irq_pin),
    .nmi_pin_i  (nmi_pin),
    .reg_sel_i  (reg_sel),
    .reg_wr_i   (reg_wr),
    .reg_addr_i (reg_addr),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .irq_req_o  (irq_req),
    .nmi_req_o  (nmi_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Pin driven at a falling edge is seen as a flag after three rising edges.
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // Arithmetic restatement of the sense codes: bit0 or code 0 reacts to a
  // high-to-low step, bit1 reacts to a low-to-high step.
  function automatic logic hits_on_fall(input logic [1:0] m);
    return (m == 2'd0) || m[0];
  endfunction
  function automatic logic hits_on_rise(input logic [1:0] m);
    return m[1];
  endfunction
  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic [7:0]  exp_f;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    @(negedge clk);
    chk("R10 reset irq_req", {8'h0, irq_req}, 16'h0);
    chk("R10 reset nmi_req", {15'h0, nmi_req}, 16'h0);
    rd_reg(3'd0, rv); chk("R10 reset nmi ctrl", rv, 16'h8000);
    rd_reg(3'd2, rv); chk("R10 reset sense", rv, 16'h0000);
    rd_reg(3'd4, rv); chk("R10 reset pend", rv, 16'h0000);
    rd_reg(3'd6, rv); chk("R10 unmapped read", rv, 16'h0000);
    wr_reg(3'd6, 16'hFFFF);
    rd_reg(3'd2, rv); chk("R10 unmapped write sense", rv, 16'h0000);
    rd_reg(3'd0, rv); chk("R10 unmapped write nmi", rv, 16'h8000);

    // R1: latency of three rising edges
    wr_reg(3'd2, 16'hAAAA);
    wr_reg(3'd4, 16'h0000);
    @(negedge clk); irq_pin[0] = 1'b0;
    settle();
    irq_pin[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 flag not yet after two edges", {8'h0, irq_req}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 flag after third edge", {8'h0, irq_req}, 16'h0001);
    wr_reg(3'd4, 16'h0000);

    // Sweep: every line with every sense code, others on both-edge mode
    for (int ln = 0; ln < 8; ln++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] cfg;
        logic [1:0]  mm;
        mm  = 2'(m);
        cfg = (16'hFFFF & ~(16'h3 << (2*ln))) | (16'(mm) << (2*ln));
        wr_reg(3'd2, cfg);
        rd_reg(3'd2, rv); chk("R2 sense readback", rv, cfg);
        wr_reg(3'd4, 16'h0000);
        chk({mode_tag(mm), " idle"}, {8'h0, irq_req}, 16'h0);
        @(negedge clk); irq_pin[ln] = 1'b0;
        settle();
        exp_f = 8'(hits_on_fall(mm)) << ln;
        chk({mode_tag(mm), " after fall"}, {8'h0, irq_req}, {8'h0, exp_f});
        rd_reg(3'd4, rv);
        chk("R9 R6 pend register vs output", rv, {8'h0, irq_req});
        wr_reg(3'd4, 16'h0000);
        exp_f = (mm == 2'd0) ? (8'h1 << ln) : 8'h0;
        chk({mode_tag(mm), " clear while low"}, {8'h0, irq_req}, {8'h0, exp_f});
        @(negedge clk); irq_pin[ln] = 1'b1;
        settle();
        exp_f = exp_f | (8'(hits_on_rise(mm)) << ln);
        chk({mode_tag(mm), " after rise"}, {8'h0, irq_req}, {8'h0, exp_f});
        wr_reg(3'd4, 16'h0000);
        chk({mode_tag(mm), " cleared"}, {8'h0, irq_req}, 16'h0);
      end
    end

    // R6: walking-zero clear masks over a full set of flags
    wr_reg(3'd2, 16'hAAAA);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); irq_pin = 8'h00;
      settle();
      irq_pin = 8'hFF;
      settle();
      chk("R4 all rising set", {8'h0, irq_req}, 16'h00FF);
      wr_reg(3'd4, 16'hFFFF & ~(16'h1 << k));
      chk("R6 single clear", {8'h0, irq_req}, {8'h0, 8'hFF & ~(8'h1 << k)});
      wr_reg(3'd4, 16'hFFFF);
      rd_reg(3'd4, rv);
      chk("R6 write ones keeps, upper zero", rv, {8'h0, 8'hFF & ~(8'h1 << k)});
      wr_reg(3'd4, 16'h0000);
    end

    // R7: clear coinciding with an event
    wr_reg(3'd2, 16'hAAAB);
    wr_reg(3'd4, 16'h0000);
    @(negedge clk); irq_pin[0] = 1'b0;
    settle();
    chk("R5 set before collision", {8'h0, irq_req}, 16'h0001);
    irq_pin[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0000;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
    chk("R7 event beats clear", {8'h0, irq_req}, 16'h0001);
    wr_reg(3'd4, 16'h0000);
    chk("R7 later clear works", {8'h0, irq_req}, 16'h0000);

    // R8: non-maskable line with both edge selections
    for (int e = 0; e < 2; e++) begin
      logic [15:0] esel;
      esel = 16'(e) << 8;
      wr_reg(3'd0, esel);
      rd_reg(3'd0, rv); chk("R8 ctrl after select", rv, 16'h8000 | esel);
      @(negedge clk); nmi_pin = 1'b0;
      settle();
      chk("R8 req after fall", {15'h0, nmi_req}, {15'h0, (e == 0)});
      rd_reg(3'd0, rv);
      chk("R8 ctrl after fall", rv, esel | ((e == 0) ? 16'h0002 : 16'h0000));
      @(negedge clk); nmi_pin = 1'b1;
      settle();
      chk("R8 req after rise", {15'h0, nmi_req}, 16'h0001);
      wr_reg(3'd0, 16'h0002 | esel);
      rd_reg(3'd0, rv); chk("R8 keep with one", rv, 16'h8002 | esel);
      wr_reg(3'd0, 16'h0000 | esel);
      rd_reg(3'd0, rv); chk("R8 clear with zero", rv, 16'h8000 | esel);
      chk("R9 nmi req follows flag", {15'h0, nmi_req}, 16'h0000);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule